// File: doc/BRIEF.md
# Synthesizer Divider Configuration Port

This block is the control logic in front of a PLL frequency synthesizer. It holds the 9-bit feedback divider value, the 3-bit output divider code and a 2-bit test selector. It presents the active divider values to the divider logic. The values come either from parallel pins, gated by an active-low parallel-load strobe, or from a three-wire serial port made of a serial clock, serial data and a serial load line.

All state runs in one fast system clock. The strobe, the serial clock, the serial load line and the serial data each pass through a two-flop synchronizer. Edges are found by comparing the synchronized sample with the previous one, so a pin change takes effect on the third rising system clock edge after it. A three-state machine decides which source owns the divider registers:
- `CFG_PAR_TRACK`: the strobe is low and the registers follow the pins.
- `CFG_HOLD`: the registers are latched and the serial port shifts.
- `CFG_SER_PASS`: the serial load line is high and every shift is copied straight to the registers.

The transitions are:
- `PAR_TRACK -> HOLD` on a strobe rise.
- `HOLD -> PAR_TRACK` and `SER_PASS -> PAR_TRACK` on a strobe fall.
- `HOLD -> SER_PASS` on a serial load rise.
- `SER_PASS -> HOLD` on a serial load fall.

A test pin carries one of four sources, chosen by the test selector. It is held low while the parallel strobe is low. A range flag tells whether the active feedback value lies in the lockable window.

Top module: `synth_cfg_port`

## Requirements
- R1: While the synchronized strobe `pload_n` is low, `m_out`/`n_out` follow `par_m`/`par_n`, with at most three system clock cycles of lag.
- R2: On a rising edge of `pload_n`, the pin values are captured. `m_out`/`n_out` then stay fixed while the pins change, until the strobe falls or a serial load occurs.
- R3: With `pload_n` high, each rising edge of `ser_clk` shifts `ser_dat` into a 14-bit word, most significant bit first. The first bit sent is T1, then T0, N2..N0, and M8..M0, with M0 last. In the word, bits [13:12] are T, bits [11:9] are N and bits [8:0] are M.
- R4: A rising edge of `ser_ld` copies the word to `t_out`, `n_out` and `m_out`. After `ser_ld` falls, further shifting with `ser_ld` low leaves these outputs unchanged.
- R5: While `ser_ld` is high and `pload_n` is high, every rising edge of `ser_clk` updates `m_out`, `n_out` and `t_out` to the newly shifted word.
- R6: `test_out` follows the value of `t_out`:
  - 00: logic 0.
  - 01: `ser_dat`.
  - 10: `mdiv_fb`.
  - 11: `synth_clk`.
- R7: `test_out` is 0 whenever the block is in parallel mode (strobe low), whatever the value of `t_out`.
- R8: `m_valid` is 1 exactly when 100 <= `m_out` <= 350.
- R9: An asserted `rst_n` (low) clears the shift word and `t_out` to 0 and loads `m_out`/`n_out` from `par_m`/`par_n`.
- R10: While the strobe is low, activity on `ser_clk` and `ser_ld` changes neither `t_out` nor the shift word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pload_n | input | 1 | Active-low parallel load strobe |
| par_m | input | 9 | Parallel feedback divider value |
| par_n | input | 3 | Parallel output divider code |
| ser_clk | input | 1 | Serial shift clock |
| ser_dat | input | 1 | Serial data |
| ser_ld | input | 1 | Serial load line |
| mdiv_fb | input | 1 | Feedback divider output, a test source |
| synth_clk | input | 1 | Synthesized clock, a test source |
| m_out | output | 9 | Active feedback divider value |
| n_out | output | 3 | Active output divider code |
| t_out | output | 2 | Active test selector bits |
| test_out | output | 1 | Test pin |
| m_valid | output | 1 | Active M lies within 100..350 |

## Verification
The bench targets several corner cases:
- The range flag at 99, 100, 350 and 351. An off-by-one comparison flips the flag at one of these edges.
- A serial word shifted with the load line low. A design that loads at each shift, rather than on the load rise, shows the new M before the load.
- Serial clocks and load pulses sent while the strobe is low, then read back by a later load. A design that shifts in parallel mode returns corrupted contents.
- The test pin with T=11 in parallel mode, which must stay low.
- A second reset after nonzero test bits, which must clear the test bits and the shift word.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;

    typedef enum logic [1:0] {
        CFG_HOLD      = 2'd0,
        CFG_PAR_TRACK = 2'd1,
        CFG_SER_PASS  = 2'd2
    } cfg_state_e;

    typedef enum logic [1:0] {
        TSEL_LOW   = 2'b00,
        TSEL_SDATA = 2'b01,
        TSEL_MFB   = 2'b10,
        TSEL_FOUT  = 2'b11
    } tsel_e;

endpackage

// File: rtl/sync_edge.sv
module sync_edge #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {(STAGES + 1){RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-1:0], d};
        end
    end

    assign lvl  = chain_q[STAGES-1];
    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall = ~chain_q[STAGES-1] & chain_q[STAGES];

endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
    parameter int WIDTH = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             din,
    output logic [WIDTH-1:0] word_q,
    output logic [WIDTH-1:0] word_next
);
    assign word_next = {word_q[WIDTH-2:0], din};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (en) begin
            word_q <= word_next;
        end
    end

    // MSB-first shift: the new bit enters at bit 0
    assert_shift_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (word_q[0] == $past(din)) && (word_q[WIDTH-1:1] == $past(word_q[WIDTH-2:0])));

endmodule

// File: rtl/cfg_fsm.sv
module cfg_fsm
    import synth_cfg_pkg::*;
#(
    parameter int M_W = 9,
    parameter int N_W = 3,
    parameter int T_W = 2,
    localparam int SR_W = M_W + N_W + T_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [M_W-1:0]  par_m,
    input  logic [N_W-1:0]  par_n,
    input  logic            pload_rise,
    input  logic            pload_fall,
    input  logic            ld_rise,
    input  logic            ld_fall,
    input  logic            shift_en,
    input  logic [SR_W-1:0] word_q,
    input  logic [SR_W-1:0] word_next,
    output cfg_state_e      state_q,
    output logic [M_W-1:0]  m_q,
    output logic [N_W-1:0]  n_q,
    output logic [T_W-1:0]  t_q
);
    cfg_state_e      state_d;
    logic [SR_W-1:0] word_src;

    assign word_src = shift_en ? word_next : word_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CFG_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_PAR_TRACK: if (pload_rise) state_d = CFG_HOLD;
            CFG_HOLD: begin
                if (pload_fall)   state_d = CFG_PAR_TRACK;
                else if (ld_rise) state_d = CFG_SER_PASS;
            end
            CFG_SER_PASS: begin
                if (pload_fall)   state_d = CFG_PAR_TRACK;
                else if (ld_fall) state_d = CFG_HOLD;
            end
            default: state_d = CFG_HOLD;
        endcase
    end

    // divider / test register outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= par_m;
            n_q <= par_n;
            t_q <= '0;
        end else begin
            unique case (state_q)
                CFG_PAR_TRACK: begin
                    m_q <= par_m;
                    n_q <= par_n;
                end
                CFG_HOLD: begin
                    if (ld_rise && !pload_fall) begin
                        m_q <= word_src[M_W-1:0];
                        n_q <= word_src[M_W+N_W-1:M_W];
                        t_q <= word_src[SR_W-1:M_W+N_W];
                    end
                end
                CFG_SER_PASS: begin
                    if (shift_en) begin
                        m_q <= word_next[M_W-1:0];
                        n_q <= word_next[M_W+N_W-1:M_W];
                        t_q <= word_next[SR_W-1:M_W+N_W];
                    end
                end
                default: ;
            endcase
        end
    end

    assert_par_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CFG_PAR_TRACK) |=> (m_q == $past(par_m)) && (n_q == $past(par_n)));

    assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CFG_HOLD && !ld_rise) |=> $stable(m_q) && $stable(n_q) && $stable(t_q));

    assert_pass_mirror_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CFG_SER_PASS) |-> (m_q == word_q[M_W-1:0]) && (t_q == word_q[SR_W-1:M_W+N_W]));

    assert_par_keeps_t_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CFG_PAR_TRACK) |=> $stable(t_q));

endmodule

// File: rtl/test_sel.sv
module test_sel
    import synth_cfg_pkg::*;
(
    input  logic       par_mode,
    input  logic [1:0] sel,
    input  logic       sdat,
    input  logic       mfb,
    input  logic       fout,
    output logic       y
);
    always_comb begin
        y = 1'b0;
        if (!par_mode) begin
            unique case (tsel_e'(sel))
                TSEL_LOW:   y = 1'b0;
                TSEL_SDATA: y = sdat;
                TSEL_MFB:   y = mfb;
                TSEL_FOUT:  y = fout;
                default:    y = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/synth_cfg_port.sv
module synth_cfg_port
    import synth_cfg_pkg::*;
#(
    parameter int M_W    = 9,
    parameter int N_W    = 3,
    parameter int T_W    = 2,
    parameter int M_MIN  = 100,
    parameter int M_MAX  = 350,
    parameter int STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pload_n,
    input  logic [M_W-1:0] par_m,
    input  logic [N_W-1:0] par_n,
    input  logic           ser_clk,
    input  logic           ser_dat,
    input  logic           ser_ld,
    input  logic           mdiv_fb,
    input  logic           synth_clk,
    output logic [M_W-1:0] m_out,
    output logic [N_W-1:0] n_out,
    output logic [T_W-1:0] t_out,
    output logic           test_out,
    output logic           m_valid
);
    localparam int SR_W = M_W + N_W + T_W;
    localparam int NCH  = 4;
    localparam logic [NCH-1:0] CH_RST = 4'b0001;
    localparam logic [M_W-1:0] M_LO = M_W'(M_MIN);
    localparam logic [M_W-1:0] M_HI = M_W'(M_MAX);

    // channels: 0 strobe, 1 serial clock, 2 serial load, 3 serial data
    logic [NCH-1:0] ch_raw, ch_lvl, ch_rise, ch_fall;
    assign ch_raw = {ser_dat, ser_ld, ser_clk, pload_n};

    for (genvar gi = 0; gi < NCH; gi++) begin : g_sync
        sync_edge #(.STAGES(STAGES), .RST_VAL(CH_RST[gi])) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (ch_raw[gi]),
            .lvl  (ch_lvl[gi]),
            .rise (ch_rise[gi]),
            .fall (ch_fall[gi])
        );
    end

    cfg_state_e      state_q;
    logic            shift_en;
    logic [SR_W-1:0] word_q, word_next;
    logic            par_mode;

    assign shift_en = ch_rise[1] && ch_lvl[0] && (state_q != CFG_PAR_TRACK);
    assign par_mode = (state_q == CFG_PAR_TRACK);

    cfg_shift #(.WIDTH(SR_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (shift_en),
        .din      (ch_lvl[3]),
        .word_q   (word_q),
        .word_next(word_next)
    );

    cfg_fsm #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .par_m     (par_m),
        .par_n     (par_n),
        .pload_rise(ch_rise[0]),
        .pload_fall(ch_fall[0]),
        .ld_rise   (ch_rise[2]),
        .ld_fall   (ch_fall[2]),
        .shift_en  (shift_en),
        .word_q    (word_q),
        .word_next (word_next),
        .state_q   (state_q),
        .m_q       (m_out),
        .n_q       (n_out),
        .t_q       (t_out)
    );

    test_sel u_tsel (
        .par_mode(par_mode),
        .sel     (t_out),
        .sdat    (ser_dat),
        .mfb     (mdiv_fb),
        .fout    (synth_clk),
        .y       (test_out)
    );

    assign m_valid = (m_out >= M_LO) && (m_out <= M_HI);

    assert_test_low_par_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CFG_PAR_TRACK) |-> !test_out);

    assert_test_zero_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (t_out == 2'b00) |-> !test_out);

    assert_no_shift_par_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CFG_PAR_TRACK) |=> $stable(word_q));

endmodule

// File: tb/synth_cfg_port_tb.sv
module synth_cfg_port_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       pload_n, ser_clk, ser_dat, ser_ld, mdiv_fb, synth_clk;
    logic [8:0] par_m, m_out;
    logic [2:0] par_n, n_out;
    logic [1:0] t_out;
    logic       test_out, m_valid;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    logic [13:0] sr_model = '0;

    always #4 clk = ~clk;

    synth_cfg_port u_dut (
        .clk(clk), .rst_n(rst_n), .pload_n(pload_n), .par_m(par_m), .par_n(par_n),
        .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_ld(ser_ld), .mdiv_fb(mdiv_fb),
        .synth_clk(synth_clk), .m_out(m_out), .n_out(n_out), .t_out(t_out),
        .test_out(test_out), .m_valid(m_valid)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic shift_bit(input logic b);
        ser_dat = b;
        wait_cyc(4);
        ser_clk = 1'b1;
        wait_cyc(4);
        ser_clk = 1'b0;
        wait_cyc(2);
        sr_model = {sr_model[12:0], b};
    endtask

    task automatic send_word(input logic [13:0] w);
        for (int i = 13; i >= 0; i--) shift_bit(w[i]);
    endtask

    task automatic load_pulse();
        ser_ld = 1'b1;
        wait_cyc(6);
        ser_ld = 1'b0;
        wait_cyc(6);
    endtask

    task automatic t_reset();
        par_m = 9'd200; par_n = 3'd3;
        rst_n = 1'b0;
        wait_cyc(3);
        chk("R9", "m at reset", m_out, 200);
        chk("R9", "n at reset", n_out, 3);
        chk("R9", "t at reset", t_out, 0);
        chk("R9", "test_out at reset", test_out, 0);
        rst_n = 1'b1;
        wait_cyc(6);
        chk("R8", "m_valid for 200", m_valid, 1);
    endtask

    task automatic t_par_track();
        pload_n = 1'b0;
        par_m = 9'd123; par_n = 3'd1;
        wait_cyc(6);
        chk("R1", "m tracks pins", m_out, 123);
        chk("R1", "n tracks pins", n_out, 1);
        par_m = 9'd77; par_n = 3'd4;
        wait_cyc(6);
        chk("R1", "m tracks second value", m_out, 77);
        chk("R1", "n tracks second value", n_out, 4);
        chk("R8", "m_valid for 77", m_valid, 0);
    endtask

    task automatic t_par_capture();
        par_m = 9'd300; par_n = 3'd5;
        wait_cyc(6);
        pload_n = 1'b1;
        wait_cyc(6);
        par_m = 9'd11; par_n = 3'd0;
        wait_cyc(8);
        chk("R2", "m held after strobe rise", m_out, 300);
        chk("R2", "n held after strobe rise", n_out, 5);
    endtask

    task automatic t_serial_load();
        send_word({2'b10, 3'd6, 9'd341});
        chk("R4", "m unchanged before load", m_out, 300);
        chk("R4", "t unchanged before load", t_out, 0);
        ser_ld = 1'b1;
        wait_cyc(6);
        chk("R3", "m from word", m_out, 341);
        chk("R3", "n from word", n_out, 6);
        chk("R3", "t from word", t_out, 2);
        mdiv_fb = 1'b1; wait_cyc(1);
        chk("R6", "sel 10 mdiv high", test_out, 1);
        mdiv_fb = 1'b0; wait_cyc(1);
        chk("R6", "sel 10 mdiv low", test_out, 0);
        ser_ld = 1'b0;
        wait_cyc(6);
        send_word({2'b00, 3'd2, 9'd150});
        chk("R4", "m latched after load fall", m_out, 341);
        chk("R4", "n latched after load fall", n_out, 6);
    endtask

    task automatic t_test_sel();
        load_pulse();
        chk("R6", "t zero", t_out, 0);
        mdiv_fb = 1'b1; synth_clk = 1'b1; ser_dat = 1'b1; wait_cyc(1);
        chk("R6", "sel 00 low", test_out, 0);
        send_word({2'b01, 3'd2, 9'd150});
        load_pulse();
        ser_dat = 1'b1; wait_cyc(1);
        chk("R6", "sel 01 sdat high", test_out, 1);
        ser_dat = 1'b0; wait_cyc(1);
        chk("R6", "sel 01 sdat low", test_out, 0);
        send_word({2'b11, 3'd7, 9'd350});
        load_pulse();
        synth_clk = 1'b1; wait_cyc(1);
        chk("R6", "sel 11 fout high", test_out, 1);
        synth_clk = 1'b0; wait_cyc(1);
        chk("R6", "sel 11 fout low", test_out, 0);
        chk("R8", "m_valid for 350", m_valid, 1);
    endtask

    task automatic t_pass_through();
        logic [13:0] w;
        ser_ld = 1'b1;
        wait_cyc(6);
        for (int k = 0; k < 3; k++) begin
            shift_bit(k[0]);
            w = sr_model;
            chk("R5", "m follows shift", m_out, int'(w[8:0]));
            chk("R5", "n follows shift", n_out, int'(w[11:9]));
            chk("R5", "t follows shift", t_out, int'(w[13:12]));
        end
        ser_ld = 1'b0;
        wait_cyc(6);
    endtask

    task automatic t_range();
        pload_n = 1'b0;
        par_m = 9'd99;  wait_cyc(6); chk("R8", "m_valid 99", m_valid, 0);
        par_m = 9'd100; wait_cyc(6); chk("R8", "m_valid 100", m_valid, 1);
        par_m = 9'd350; wait_cyc(6); chk("R8", "m_valid 350", m_valid, 1);
        par_m = 9'd351; wait_cyc(6); chk("R8", "m_valid 351", m_valid, 0);
        pload_n = 1'b1;
        wait_cyc(6);
    endtask

    task automatic t_par_ignores_serial();
        logic [13:0] saved;
        send_word({2'b11, 3'd1, 9'd222});
        load_pulse();
        saved = sr_model;
        pload_n = 1'b0;
        par_m = 9'd250; par_n = 3'd2;
        synth_clk = 1'b1;
        wait_cyc(6);
        chk("R7", "test_out low in parallel, sel 11", test_out, 0);
        for (int k = 0; k < 3; k++) begin
            ser_dat = 1'b0; wait_cyc(4);
            ser_clk = 1'b1; wait_cyc(4);
            ser_clk = 1'b0; wait_cyc(2);
        end
        load_pulse();
        chk("R10", "t unchanged in parallel", t_out, 3);
        chk("R1", "m still pins", m_out, 250);
        pload_n = 1'b1;
        wait_cyc(6);
        par_m = 9'd5;
        ser_ld = 1'b1;
        wait_cyc(6);
        chk("R10", "shift word kept m", m_out, int'(saved[8:0]));
        chk("R10", "shift word kept n", n_out, int'(saved[11:9]));
        ser_ld = 1'b0;
        wait_cyc(6);
    endtask

    task automatic t_reset_again();
        par_m = 9'd180; par_n = 3'd4;
        rst_n = 1'b0;
        wait_cyc(2);
        chk("R9", "t cleared by reset", t_out, 0);
        chk("R9", "m loaded from pins", m_out, 180);
        rst_n = 1'b1;
        wait_cyc(6);
        ser_ld = 1'b1;
        wait_cyc(6);
        chk("R9", "shift word cleared m", m_out, 0);
        chk("R9", "shift word cleared n", n_out, 0);
        chk("R9", "shift word cleared t", t_out, 0);
        ser_ld = 1'b0;
        wait_cyc(6);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        pload_n = 1'b1; ser_clk = 1'b0; ser_dat = 1'b0; ser_ld = 1'b0;
        mdiv_fb = 1'b0; synth_clk = 1'b0;
        t_reset();
        t_par_track();
        t_par_capture();
        t_serial_load();
        t_test_sel();
        t_pass_through();
        t_range();
        t_par_ignores_serial();
        t_reset_again();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule